// File: doc/BRIEF.md
# Integer ALU with Two-Cycle Multiplier

A 32-bit integer execution unit for a small pipelined processor. Each accepted operation takes two operands and a 4-bit operation code. It returns a registered result, a result-valid strobe, four condition flags and a flag write enable. Addition, subtraction, the bitwise operations, the three shifts and bit reversal finish one clock after acceptance. The three multiply forms (low word, unsigned high word, signed high word) take a second clock. During that second clock the unit reports busy and ignores new work.

Control is a two-state machine. `ST_IDLE` accepts a single-cycle operation and stays in `ST_IDLE`, or accepts a multiply and moves to `ST_MUL` (transition *start_mul*). `ST_MUL` always returns to `ST_IDLE` on the next edge. That transition is either *finish_mul*, which publishes the product, or *abort_mul*, which happens when the clear input is high and drops the product. In either state, a high clear input leaves the unit in `ST_IDLE` with nothing pending.

Bit reversal writes its result without touching the flags, so software can use it as a plain move. Shift counts come from the low six bits of the second operand. The carry is the last bit that leaves the word. Counts of 32 and above give fully defined results.

Top module: `int_alu`

## Requirements
- R1: ADD (code 0) returns a+b, with carry equal to the unsigned carry out and overflow equal to signed overflow. SUB (code 1) returns a-b, with carry set when a < b unsigned (borrow) and overflow set on signed overflow.
- R2: AND (2), OR (3) and XOR (4) return the bitwise result, with carry and overflow both 0.
- R3: flags_o is {overflow[3], negative[2], carry[1], zero[0]}. For every operation that updates flags, zero is set when the 32-bit result is 0 and negative is result bit 31. flags_we_o is high exactly together with such a result, and is never high without res_valid_o.
- R4: The logical shifts SHL (5) and SHR (6) shift by opb[5:0] and ignore the higher bits of opb. Carry is the last bit shifted out. A count of 0 returns a unchanged with carry 0. SHR of 0x80000000 by 32 gives 0 with carry 1, and SHL of 1 by 32 gives 0 with carry 1. A count above 32 gives 0 with carry 0. Overflow is 0.
- R5: SAR (7) shifts right by opb[5:0], filling with bit 31, and carry is the last bit shifted out. A count of 32 or more gives all bits equal to a[31], with carry equal to a[31]. A count of 0 gives a with carry 0.
- R6: BREV (8) returns a with bit i moved to bit 31-i. flags_we_o stays low and flags_o keeps its previous value.
- R7: A single-cycle operation accepted at a clock edge gives res_valid_o high for exactly the following cycle, with busy_o low.
- R8: MULLO (9) returns the low 32 bits of a*b. MULUH (10) returns the high 32 bits with both operands unsigned. MULSH (11) returns the high 32 bits with both operands signed. Carry and overflow are 0. busy_o is high, and res_valid_o low, in the cycle after acceptance. res_valid_o is high in the cycle after that.
- R9: While busy_o is high, in_valid_i is ignored: no extra result is produced, and the pending multiply completes unaffected.
- R10: clr_i high at an edge drops a pending multiply and accepts no operation. After that edge, res_valid_o and busy_o are low.
- R11: Codes 12 to 15 are ignored: no result, no flag write.
- R12: After reset, res_valid_o, busy_o and flags_we_o are 0, and flags_o and result_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Abort pending multiply, block acceptance |
| in_valid_i | input | 1 | Operation present |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand / shift count |
| result_o | output | 32 | Result |
| res_valid_o | output | 1 | Result valid strobe |
| busy_o | output | 1 | Multiply in progress |
| flags_o | output | 4 | {V,N,C,Z} condition flags |
| flags_we_o | output | 1 | Flag update enable |

## Verification
The bench probes the shift boundaries: counts 0, 1, 31, 32, 33 and 63, and a count with high bits set in the second operand. A shifter that masked the count to five bits, or took carry from the wrong end, would return a nonzero word or the wrong carry at 32. Each multiply form uses operands with the top bit set, so a signed/unsigned mix-up changes the high word. Bit reversal runs right after a flag-setting add, so a design that wrote flags on it would show changed flags. A new operation arrives while busy and a clear arrives mid-multiply; these catch a design that starts a second operation or still publishes an aborted product.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SHL   = 4'd5,
        OP_SHR   = 4'd6,
        OP_SAR   = 4'd7,
        OP_BREV  = 4'd8,
        OP_MULLO = 4'd9,
        OP_MULUH = 4'd10,
        OP_MULSH = 4'd11
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MUL  = 1'b1
    } alu_state_e;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int NFLAGS = 4;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ov
);
    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic [W-1:0] rev;

    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = a[W-1-i];
    end

    always_comb begin
        res = '0;
        cy  = 1'b0;
        ov  = 1'b0;
        unique case (op)
            OP_ADD: begin
                res = sum_x[W-1:0];
                cy  = sum_x[W];
                ov  = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
            end
            OP_SUB: begin
                res = dif_x[W-1:0];
                cy  = dif_x[W];
                ov  = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_BREV: res = rev;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  res,
    output logic          cy
);
    logic [W:0] left_x;
    logic [W:0] right_x;
    logic [W:0] arith_x;

    // One guard bit catches the last bit leaving the word.
    assign left_x  = {1'b0, a} << cnt;
    assign right_x = {a, 1'b0} >> cnt;
    assign arith_x = $signed({a, 1'b0}) >>> cnt;

    always_comb begin
        res = '0;
        cy  = 1'b0;
        unique case (op)
            OP_SHL: {cy, res} = left_x;
            OP_SHR: {res, cy} = right_x;
            OP_SAR: {res, cy} = arith_x;
            default: begin
                res = '0;
                cy  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ea_q, eb_q, prod;
    logic          hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q <= '0;
            eb_q <= '0;
            hi_q <= 1'b0;
        end else if (load) begin
            ea_q <= (op == OP_MULSH) ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
            eb_q <= (op == OP_MULSH) ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
            hi_q <= (op != OP_MULLO);
        end
    end

    assign prod = ea_q * eb_q;
    assign res  = hi_q ? prod[PW-1:W] : prod[W-1:0];
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              in_valid_i,
    input  logic [3:0]        op_i,
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    output logic [W-1:0]      result_o,
    output logic              res_valid_o,
    output logic              busy_o,
    output logic [NFLAGS-1:0] flags_o,
    output logic              flags_we_o
);
    localparam int CW = $clog2(W) + 1;

    alu_state_e state_q, state_n;
    alu_op_e    op;
    logic       op_ok, is_mul, is_shift, accept;
    logic [W-1:0] ar_res, sh_res, mu_res, one_res;
    logic         ar_cy, ar_ov, sh_cy, one_cy, one_ov, one_we;

    assign op       = alu_op_e'(op_i);
    assign op_ok    = (op_i <= 4'(OP_MULSH));
    assign is_mul   = (op == OP_MULLO) || (op == OP_MULUH) || (op == OP_MULSH);
    assign is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
    assign accept   = in_valid_i && !clr_i && op_ok && (state_q == ST_IDLE);

    alu_arith #(.W(W)) arith_i (
        .op(op), .a(opa_i), .b(opb_i), .res(ar_res), .cy(ar_cy), .ov(ar_ov)
    );

    alu_shift #(.W(W), .CW(CW)) shift_i (
        .op(op), .a(opa_i), .cnt(opb_i[CW-1:0]), .res(sh_res), .cy(sh_cy)
    );

    alu_mul #(.W(W)) mul_i (
        .clk(clk), .rst_n(rst_n), .load(accept && is_mul), .op(op),
        .a(opa_i), .b(opb_i), .res(mu_res)
    );

    assign one_res = is_shift ? sh_res : ar_res;
    assign one_cy  = is_shift ? sh_cy  : ar_cy;
    assign one_ov  = is_shift ? 1'b0   : ar_ov;
    assign one_we  = (op != OP_BREV);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && is_mul) state_n = ST_MUL;
            ST_MUL:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (clr_i) state_n = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o    <= '0;
            res_valid_o <= 1'b0;
            flags_o     <= '0;
            flags_we_o  <= 1'b0;
        end else if (clr_i) begin
            res_valid_o <= 1'b0;
            flags_we_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    res_valid_o <= 1'b0;
                    flags_we_o  <= 1'b0;
                    if (accept && !is_mul) begin
                        result_o    <= one_res;
                        res_valid_o <= 1'b1;
                        flags_we_o  <= one_we;
                        if (one_we)
                            flags_o <= {one_ov, one_res[W-1], one_cy, (one_res == '0)};
                    end
                end
                ST_MUL: begin
                    result_o    <= mu_res;
                    res_valid_o <= 1'b1;
                    flags_we_o  <= 1'b1;
                    flags_o     <= {1'b0, mu_res[W-1], 1'b0, (mu_res == '0)};
                end
                default: begin
                    res_valid_o <= 1'b0;
                    flags_we_o  <= 1'b0;
                end
            endcase
        end
    end

    assign busy_o = (state_q == ST_MUL);

    assert_single_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_mul) |=> (res_valid_o && !busy_o));
    assert_mul_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_mul) |=> (busy_o && !res_valid_o));
    assert_mul_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !clr_i) |=> (res_valid_o && !busy_o));
    assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!res_valid_o && !busy_o));
    assert_brev_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_BREV) |=> (!flags_we_o && $stable(flags_o)));
    assert_unused_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !op_ok && !busy_o) |=> !res_valid_o);
    assert_we_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> res_valid_o);
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [31:0] result_o;
    logic        res_valid_o, busy_o, flags_we_o;
    logic [3:0]  flags_o;

    int total = 0;
    int bad = 0;
    logic [3:0] held_flags = '0;

    always #2 clk = ~clk;

    int_alu dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .in_valid_i(in_valid_i),
        .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
        .res_valid_o(res_valid_o), .busy_o(busy_o), .flags_o(flags_o),
        .flags_we_o(flags_we_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic [3:0] f, output logic we);
        logic c, v;
        longint s;
        logic [63:0] p;
        int n;
        c = 0; v = 0; we = 1; r = '0; n = int'(b[5:0]);
        case (op)
            4'd0: begin r = a + b; c = (33'(a) + 33'(b)) > 33'hFFFFFFFF;
                  s = longint'($signed(a)) + longint'($signed(b));
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'd1: begin r = a - b; c = (a < b);
                  s = longint'($signed(a)) - longint'($signed(b));
                  v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: begin r = a; for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end end
            4'd6: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end end
            4'd7: begin r = a; for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end end
            4'd8: begin we = 0; for (int i = 0; i < 32; i++) r[i] = a[31-i]; end
            4'd9:  begin p = {32'd0, a} * {32'd0, b}; r = p[31:0]; end
            4'd10: begin p = {32'd0, a} * {32'd0, b}; r = p[63:32]; end
            4'd11: begin p = 64'($signed(a)) * 64'($signed(b)); r = p[63:32]; end
            default: r = '0;
        endcase
        f = {v, r[31], c, (r == 32'd0)};
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] er; logic [3:0] ef; logic ewe;
        model(op, a, b, er, ef, ewe);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
        if (op >= 4'd9) begin
            chk(busy_o && !res_valid_o, {req, " busy phase"}, {busy_o, res_valid_o}, 2'b10);
            @(negedge clk);
        end
        chk(res_valid_o && !busy_o, {req, " valid"}, {res_valid_o, busy_o}, 2'b10);
        chk(result_o == er, {req, " result"}, result_o, er);
        chk(flags_we_o == ewe, {req, " flag we (R3)"}, flags_we_o, ewe);
        if (ewe) held_flags = ef;
        chk(flags_o == held_flags, {req, " flags (R3)"}, flags_o, held_flags);
        @(negedge clk);
        chk(!res_valid_o, {req, " one-cycle strobe (R7)"}, res_valid_o, 0);
    endtask

    task automatic test_reset();
        chk(!res_valid_o && !busy_o && !flags_we_o && flags_o == 0 && result_o == 0, "R12 reset",
            {res_valid_o, busy_o, flags_we_o, flags_o, result_o}, 0);
    endtask

    task automatic test_addsub();
        run_op(4'd0, 32'd5, 32'd7, "R1 add");
        run_op(4'd0, 32'hFFFFFFFF, 32'd1, "R1 add carry");
        run_op(4'd0, 32'h7FFFFFFF, 32'd1, "R1 add overflow");
        run_op(4'd1, 32'd3, 32'd5, "R1 sub borrow");
        run_op(4'd1, 32'h80000000, 32'd1, "R1 sub overflow");
        run_op(4'd1, 32'd9, 32'd9, "R1 sub zero");
    endtask

    task automatic test_logic();
        run_op(4'd2, 32'hF0F0F0F0, 32'hFF00FF00, "R2 and");
        run_op(4'd3, 32'h0000000F, 32'h80000000, "R2 or");
        run_op(4'd4, 32'h12345678, 32'h12345678, "R2 xor");
    endtask

    task automatic test_shifts();
        run_op(4'd6, 32'h80000000, 32'd32, "R4 shr 32");
        run_op(4'd6, 32'hFFFFFFFF, 32'd33, "R4 shr 33");
        run_op(4'd6, 32'h00000003, 32'd1, "R4 shr 1");
        run_op(4'd6, 32'h12345678, 32'd0, "R4 shr 0");
        run_op(4'd5, 32'h00000001, 32'd32, "R4 shl 32");
        run_op(4'd5, 32'hC0000001, 32'd1, "R4 shl 1");
        run_op(4'd5, 32'hFFFFFFFF, 32'd63, "R4 shl 63");
        run_op(4'd5, 32'h00000001, 32'hFFFFFF1F, "R4 shl high count bits ignored");
        run_op(4'd7, 32'h80000000, 32'd40, "R5 sar 40");
        run_op(4'd7, 32'h7FFFFFFF, 32'd32, "R5 sar 32 positive");
        run_op(4'd7, 32'h80000007, 32'd1, "R5 sar 1");
        run_op(4'd7, 32'h80000000, 32'd0, "R5 sar 0");
    endtask

    task automatic test_brev();
        run_op(4'd1, 32'd1, 32'd2, "R6 setup flags");
        run_op(4'd8, 32'h00000001, 32'd0, "R6 brev");
        run_op(4'd8, 32'h12345678, 32'd0, "R6 brev pattern");
    endtask

    task automatic test_mul();
        run_op(4'd9,  32'hFFFFFFFF, 32'hFFFFFFFF, "R8 mullo");
        run_op(4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, "R8 muluh");
        run_op(4'd11, 32'hFFFFFFFF, 32'hFFFFFFFF, "R8 mulsh");
        run_op(4'd11, 32'h80000000, 32'd3, "R8 mulsh mixed sign");
        run_op(4'd10, 32'h80000000, 32'd3, "R8 muluh top bit");
        run_op(4'd9,  32'h00010000, 32'h00010000, "R8 mullo zero");
    endtask

    task automatic test_busy_ignore();
        logic [63:0] p;
        p = {32'd0, 32'h89ABCDEF} * {32'd0, 32'h01234567};
        @(negedge clk);
        op_i = 4'd10; opa_i = 32'h89ABCDEF; opb_i = 32'h01234567; in_valid_i = 1'b1;
        @(negedge clk);
        op_i = 4'd0; opa_i = 32'd1; opb_i = 32'd1;
        chk(busy_o, "R9 busy", busy_o, 1);
        @(negedge clk);
        in_valid_i = 1'b0;
        chk(res_valid_o && result_o == p[63:32], "R9 mul unaffected", result_o, p[63:32]);
        held_flags = {1'b0, p[63], 1'b0, 1'b0};
        @(negedge clk);
        chk(!res_valid_o, "R9 no extra result", res_valid_o, 0);
    endtask

    task automatic test_clear();
        @(negedge clk);
        op_i = 4'd9; opa_i = 32'd6; opb_i = 32'd7; in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk(!res_valid_o && !busy_o, "R10 abort multiply", {res_valid_o, busy_o}, 0);
        @(negedge clk);
        chk(!res_valid_o, "R10 no late result", res_valid_o, 0);
        op_i = 4'd0; opa_i = 32'd1; opb_i = 32'd1; in_valid_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; clr_i = 1'b0;
        chk(!res_valid_o, "R10 clear blocks accept", res_valid_o, 0);
        run_op(4'd0, 32'd2, 32'd3, "R10 recovers");
    endtask

    task automatic test_unused();
        for (int k = 12; k < 16; k++) begin
            @(negedge clk);
            op_i = 4'(k); opa_i = 32'd1; opb_i = 32'd1; in_valid_i = 1'b1;
            @(negedge clk);
            in_valid_i = 1'b0;
            chk(!res_valid_o && !flags_we_o && !busy_o && flags_o == held_flags, "R11 unused code",
                {res_valid_o, flags_we_o, busy_o, flags_o}, {3'b000, held_flags});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        test_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_addsub();
        test_logic();
        test_shifts();
        test_brev();
        test_mul();
        test_busy_ignore();
        test_clear();
        test_unused();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule